// File: doc/BRIEF.md
# 16-bit ALU with condition flags

This block is the arithmetic/logic unit of a small 16-bit processor, together with its four registered condition flags: zero (Z), negative (N), carry (C) and overflow (O). It takes two 16-bit operands, a 4-bit operation code, a small immediate and a path select. The result is produced combinationally in the same cycle. The flags are written on the next rising clock edge, and only when the flag-update enable is high.

A path select picks one of four uses. The register-register arithmetic path is driven by the operation code. The signed add-immediate path and the load-upper-immediate path ignore the operation code. The idle path produces a zero result. Each operation writes only its own defined subset of the flags. The rotate operations pass through the stored carry but leave it unchanged. The add-with-carry and subtract-with-borrow operations read the stored carry, so multi-word arithmetic can be built by chaining them.

Top module: `alu_flags_core`

## Requirements
- R1: On the arithmetic path, codes 0, 1, 6 and 7 give the bitwise results opA AND opB, opA OR opB, opA XOR opB and NOT opA. They write only N and Z, so C and O keep their values.
- R2: Whenever an operation writes N and Z, N takes result bit 15 and Z is 1 exactly when all 16 result bits are zero.
- R3: Code 4 gives opA+opB and sets C to the carry out of bit 15. Code 5 gives opA-opB and sets C to 1 when no borrow occurs (opA >= opB unsigned). Neither writes O.
- R4: Code 8 gives opA+opB+C and code 9 gives opA-opB-(1-C), where C is the stored carry. Both set C as in R3, which lets multi-word operations chain through the carry.
- R5: Code 2 shifts opA left by one and code 3 shifts it right by one. The vacated bit is zero, and C takes the bit shifted out (bit 15 for code 2, bit 0 for code 3). N and Z are written; O is not.
- R6: Code 10 gives {opA[14:0], C} and code 11 gives {C, opA[15:1]}. Both write only N and Z, so C and O stay unchanged.
- R7: On the add-immediate path (pathSel=1), imm[5:0] is sign-extended and added to opA, and imm[9:6] is ignored. All four flags are written: C is the unsigned carry out of bit 15, and O is 1 on signed overflow.
- R8: On the load-upper path (pathSel=2), the result is {imm[9:0], 6'b0}, opA and opB have no effect, and no flag changes.
- R9: Arithmetic codes 12 to 15, and the idle path (pathSel=3), give a zero result and change no flag.
- R10: When flagEn is 0, no flag changes, whatever the operation. The result is still produced.
- R11: While rstN is low, all four flags are 0.
- R12: The O flag changes only on the add-immediate path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the flags |
| pathSel | input | 2 | 0 arithmetic, 1 add-immediate, 2 load-upper, 3 idle |
| opCode | input | 4 | Operation code for the arithmetic path |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| imm | input | 10 | Immediate; the low 6 bits are used by add-immediate, all 10 by load-upper |
| flagEn | input | 1 | Enables the flag update for this cycle |
| result | output | 16 | Combinational result |
| flagZ | output | 1 | Zero flag |
| flagN | output | 1 | Negative flag |
| flagC | output | 1 | Carry flag |
| flagO | output | 1 | Overflow flag |

## Verification
The sweep runs every operation code over a grid of operands at the boundaries (0, 1, 0x7FFF, 0x8000, 0xFFFF and others). Before each operation it forces the stored carry to both 0 and 1. This catches a chained add or subtract whose carry-in is inverted or ignored, a rotate that fills with zero instead of the carry, and a rotate that overwrites C. It also catches a subtract that reports borrow instead of no-borrow. Flags are compared after every operation, so a logical operation or a rotate that writes C, or any non-immediate operation that writes O, shows up as a changed flag. The add-immediate sweep covers all 64 immediates with junk in the upper immediate bits, which exposes a wrong sign extension or a wrong overflow rule. The reserved codes, the idle path and disabled updates are each checked for an unchanged flag set.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

  localparam int NFLAGS = 4;
  localparam int FLAG_Z = 0;
  localparam int FLAG_N = 1;
  localparam int FLAG_C = 2;
  localparam int FLAG_O = 3;

  typedef enum logic [1:0] {
    PATH_ARITH = 2'd0,
    PATH_ADDI  = 2'd1,
    PATH_LUI   = 2'd2,
    PATH_IDLE  = 2'd3
  } path_e;

  typedef enum logic [3:0] {
    FN_ZERO, FN_AND, FN_OR, FN_XOR, FN_NOT,
    FN_SHL, FN_SHR, FN_ROL, FN_ROR, FN_SUM, FN_LUI
  } fn_e;

  typedef enum logic [1:0] {
    CIN_ZERO, CIN_ONE, CIN_FLAG
  } cin_e;

  // Strobes from control to datapath
  typedef struct packed {
    fn_e               fn;
    logic              invB;
    logic              useImm;
    cin_e              cinSel;
    logic [NFLAGS-1:0] upd;
  } strobe_t;

endpackage

// File: rtl/alu_ctrl.sv
`timescale 1ns/1ps
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [1:0] pathSel,
  input  logic [3:0] opCode,
  input  logic       flagEn,
  output strobe_t    strb
);

  localparam logic [NFLAGS-1:0] MASK_NZ  = (1 << FLAG_N) | (1 << FLAG_Z);
  localparam logic [NFLAGS-1:0] MASK_CNZ = MASK_NZ | (1 << FLAG_C);
  localparam logic [NFLAGS-1:0] MASK_ALL = MASK_CNZ | (1 << FLAG_O);

  logic [NFLAGS-1:0] updRaw;

  always_comb begin
    strb.fn     = FN_ZERO;
    strb.invB   = 1'b0;
    strb.useImm = 1'b0;
    strb.cinSel = CIN_ZERO;
    updRaw      = '0;
    case (pathSel)
      PATH_ARITH: begin
        case (opCode)
          4'd0:  begin strb.fn = FN_AND; updRaw = MASK_NZ; end
          4'd1:  begin strb.fn = FN_OR;  updRaw = MASK_NZ; end
          4'd2:  begin strb.fn = FN_SHL; updRaw = MASK_CNZ; end
          4'd3:  begin strb.fn = FN_SHR; updRaw = MASK_CNZ; end
          4'd4:  begin strb.fn = FN_SUM; updRaw = MASK_CNZ; end
          4'd5:  begin
            strb.fn = FN_SUM; strb.invB = 1'b1; strb.cinSel = CIN_ONE; updRaw = MASK_CNZ;
          end
          4'd6:  begin strb.fn = FN_XOR; updRaw = MASK_NZ; end
          4'd7:  begin strb.fn = FN_NOT; updRaw = MASK_NZ; end
          4'd8:  begin strb.fn = FN_SUM; strb.cinSel = CIN_FLAG; updRaw = MASK_CNZ; end
          4'd9:  begin
            strb.fn = FN_SUM; strb.invB = 1'b1; strb.cinSel = CIN_FLAG; updRaw = MASK_CNZ;
          end
          4'd10: begin strb.fn = FN_ROL; updRaw = MASK_NZ; end
          4'd11: begin strb.fn = FN_ROR; updRaw = MASK_NZ; end
          default: begin strb.fn = FN_ZERO; updRaw = '0; end
        endcase
      end
      PATH_ADDI: begin
        strb.fn = FN_SUM; strb.useImm = 1'b1; updRaw = MASK_ALL;
      end
      PATH_LUI: strb.fn = FN_LUI;
      default:  strb.fn = FN_ZERO;
    endcase
    strb.upd = flagEn ? updRaw : '0;
  end

endmodule

// File: rtl/alu_datapath.sv
`timescale 1ns/1ps
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DW  = 16,
  parameter int AIW = 6,
  parameter int LIW = 10
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DW-1:0]     opA,
  input  logic [DW-1:0]     opB,
  input  logic [LIW-1:0]    imm,
  output logic [DW-1:0]     result,
  output logic [NFLAGS-1:0] flags
);

  localparam int LOW_CLR = DW - LIW;

  logic [DW-1:0]     bSel;
  logic              cin;
  logic [DW:0]       sum;
  logic              carryOut;
  logic              ovf;
  logic [NFLAGS-1:0] nxt;

  always_comb begin
    if (strb.useImm)    bSel = {{(DW-AIW){imm[AIW-1]}}, imm[AIW-1:0]};
    else if (strb.invB) bSel = ~opB;
    else                bSel = opB;
    case (strb.cinSel)
      CIN_ONE:  cin = 1'b1;
      CIN_FLAG: cin = flags[FLAG_C];
      default:  cin = 1'b0;
    endcase
  end

  assign sum = {1'b0, opA} + {1'b0, bSel} + {{DW{1'b0}}, cin};
  assign ovf = (opA[DW-1] == bSel[DW-1]) && (sum[DW-1] != opA[DW-1]);

  always_comb begin
    carryOut = 1'b0;
    case (strb.fn)
      FN_AND: result = opA & opB;
      FN_OR:  result = opA | opB;
      FN_XOR: result = opA ^ opB;
      FN_NOT: result = ~opA;
      FN_SHL: begin result = {opA[DW-2:0], 1'b0}; carryOut = opA[DW-1]; end
      FN_SHR: begin result = {1'b0, opA[DW-1:1]}; carryOut = opA[0]; end
      FN_ROL: result = {opA[DW-2:0], flags[FLAG_C]};
      FN_ROR: result = {flags[FLAG_C], opA[DW-1:1]};
      FN_SUM: begin result = sum[DW-1:0]; carryOut = sum[DW]; end
      FN_LUI: result = {imm, {LOW_CLR{1'b0}}};
      default: result = '0;
    endcase
  end

  always_comb begin
    nxt         = '0;
    nxt[FLAG_Z] = ~|result;
    nxt[FLAG_N] = result[DW-1];
    nxt[FLAG_C] = carryOut;
    nxt[FLAG_O] = ovf;
  end

  for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            flags[g] <= 1'b0;
      else if (strb.upd[g]) flags[g] <= nxt[g];
    end
  end

  // R2: a written Z flag reflects the result of the cycle before
  a_r2_zero_tracks: assert property (@(posedge clk) disable iff (!rstN)
    strb.upd[FLAG_Z] |=> (flags[FLAG_Z] == ($past(result) == '0)));

  // R2: a written N flag is the sign of the result of the cycle before
  a_r2_sign_tracks: assert property (@(posedge clk) disable iff (!rstN)
    strb.upd[FLAG_N] |=> (flags[FLAG_N] == $past(result[DW-1])));

  // R11: flags are clear during reset
  always_comb begin
    if (!rstN) a_r11_reset_clear: assert (flags == '0);
  end

endmodule

// File: rtl/alu_flags_core.sv
`timescale 1ns/1ps
module alu_flags_core
  import alu_pkg::*;
#(
  parameter int DW  = 16,
  parameter int AIW = 6,
  parameter int LIW = 10
)(
  input  logic           clk,
  input  logic           rstN,
  input  logic [1:0]     pathSel,
  input  logic [3:0]     opCode,
  input  logic [DW-1:0]  opA,
  input  logic [DW-1:0]  opB,
  input  logic [LIW-1:0] imm,
  input  logic           flagEn,
  output logic [DW-1:0]  result,
  output logic           flagZ,
  output logic           flagN,
  output logic           flagC,
  output logic           flagO
);

  localparam int LOW_CLR = DW - LIW;

  strobe_t           strb;
  logic [NFLAGS-1:0] flags;

  alu_ctrl u_ctrl (
    .pathSel (pathSel),
    .opCode  (opCode),
    .flagEn  (flagEn),
    .strb    (strb)
  );

  alu_datapath #(.DW(DW), .AIW(AIW), .LIW(LIW)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .opA    (opA),
    .opB    (opB),
    .imm    (imm),
    .result (result),
    .flags  (flags)
  );

  assign flagZ = flags[FLAG_Z];
  assign flagN = flags[FLAG_N];
  assign flagC = flags[FLAG_C];
  assign flagO = flags[FLAG_O];

  // R10: disabled update holds every flag
  a_r10_hold_flags: assert property (@(posedge clk) disable iff (!rstN)
    !flagEn |=> $stable(flags));

  // R12: overflow only moves on the add-immediate path
  a_r12_o_only_addi: assert property (@(posedge clk) disable iff (!rstN)
    (pathSel != PATH_ADDI) |=> $stable(flagO));

  // R6: rotates keep the carry
  a_r6_rot_keeps_c: assert property (@(posedge clk) disable iff (!rstN)
    (pathSel == PATH_ARITH && (opCode == 4'd10 || opCode == 4'd11)) |=> $stable(flagC));

  // R1: logical operations keep the carry
  a_r1_logic_keeps_c: assert property (@(posedge clk) disable iff (!rstN)
    (pathSel == PATH_ARITH && (opCode == 4'd0 || opCode == 4'd1 || opCode == 4'd6 || opCode == 4'd7))
    |=> $stable(flagC));

  // R9: reserved codes and the idle path give zero and keep all flags
  a_r9_reserved_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (pathSel == PATH_IDLE || (pathSel == PATH_ARITH && opCode >= 4'd12))
    |-> (result == '0) ##1 $stable(flags));

  // R8: load-upper places the immediate on top and clears the rest
  a_r8_lui_shape: assert property (@(posedge clk) disable iff (!rstN)
    (pathSel == PATH_LUI) |-> (result[LOW_CLR-1:0] == '0 && result[DW-1:LOW_CLR] == imm));

endmodule

// File: tb/sim_alu_flags_core.sv
`timescale 1ns/1ps
module sim_alu_flags_core;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  pathSel = 2'd3;
  logic [3:0]  opCode = 4'd0;
  logic [15:0] opA = 16'h0, opB = 16'h0;
  logic [9:0]  imm = 10'h0;
  logic        flagEn = 1'b0;
  logic [15:0] result;
  logic        flagZ, flagN, flagC, flagO;

  int nVec = 0;
  int nBad = 0;
  bit done = 0;

  // model flags
  bit mZ = 0, mN = 0, mC = 0, mO = 0;

  always #10 clk = ~clk;  // 50 MHz

  alu_flags_core u0 (
    .clk(clk), .rstN(rstN), .pathSel(pathSel), .opCode(opCode),
    .opA(opA), .opB(opB), .imm(imm), .flagEn(flagEn),
    .result(result), .flagZ(flagZ), .flagN(flagN), .flagC(flagC), .flagO(flagO)
  );

  function automatic logic [15:0] patVal(int i);
    case (i)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'h0002;
      3: return 16'h7FFF;  4: return 16'h8000;  5: return 16'h8001;
      6: return 16'hFFFF;  7: return 16'hFFFE;  8: return 16'h5555;
      9: return 16'hAAAA; 10: return 16'h00FF; default: return 16'h1234;
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    nVec++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s got=%h expected=%h (path=%0d op=%0d a=%h b=%h imm=%h)",
               tag, got, exp, pathSel, opCode, opA, opB, imm);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  endtask

  task automatic runOp(logic [1:0] p, logic [3:0] op, logic [15:0] a, logic [15:0] b,
                       logic [9:0] iv, bit en);
    int ia, ib, full, s, sg;
    logic [15:0] expR;
    bit eZ, eN, eC, eO, wNZ, wC, wO;
    string tag;
    @(negedge clk);
    pathSel = p; opCode = op; opA = a; opB = b; imm = iv; flagEn = en;
    ia = int'(a); ib = int'(b);
    expR = 16'h0; eC = mC; eO = mO; wNZ = 0; wC = 0; wO = 0; tag = "R9";
    if (p == 2'd0) begin
      case (op)
        4'd0: begin expR = a & b; wNZ = 1; tag = "R1"; end
        4'd1: begin expR = a | b; wNZ = 1; tag = "R1"; end
        4'd6: begin expR = a ^ b; wNZ = 1; tag = "R1"; end
        4'd7: begin expR = ~a;    wNZ = 1; tag = "R1"; end
        4'd2: begin expR = 16'((ia * 2) % 65536); eC = a[15]; wNZ = 1; wC = 1; tag = "R5"; end
        4'd3: begin expR = 16'(ia / 2); eC = a[0]; wNZ = 1; wC = 1; tag = "R5"; end
        4'd4: begin full = ia + ib; expR = 16'(full); eC = full > 65535; wNZ = 1; wC = 1; tag = "R3"; end
        4'd5: begin full = ia - ib; expR = 16'(full); eC = full >= 0; wNZ = 1; wC = 1; tag = "R3"; end
        4'd8: begin full = ia + ib + int'(mC); expR = 16'(full); eC = full > 65535; wNZ = 1; wC = 1; tag = "R4"; end
        4'd9: begin full = ia - ib - (1 - int'(mC)); expR = 16'(full); eC = full >= 0; wNZ = 1; wC = 1; tag = "R4"; end
        4'd10: begin expR = 16'((ia * 2) % 65536 + int'(mC)); wNZ = 1; tag = "R6"; end
        4'd11: begin expR = 16'(ia / 2 + int'(mC) * 32768); wNZ = 1; tag = "R6"; end
        default: begin expR = 16'h0; tag = "R9"; end
      endcase
    end else if (p == 2'd1) begin
      s = iv[5] ? int'(iv[5:0]) - 64 : int'(iv[5:0]);
      full = ia + (s & 16'hFFFF);
      sg = int'($signed(a)) + s;
      expR = 16'(ia + s);
      eC = full > 65535; eO = (sg > 32767) || (sg < -32768);
      wNZ = 1; wC = 1; wO = 1; tag = "R7";
    end else if (p == 2'd2) begin
      expR = {iv, 6'b0}; tag = "R8";
    end
    eZ = (expR == 16'h0); eN = expR[15];
    #2;
    check($sformatf("%s result", tag), result, expR);
    if (!en) begin wNZ = 0; wC = 0; wO = 0; tag = "R10"; end
    if (wNZ) begin mZ = eZ; mN = eN; end
    if (wC) mC = eC;
    if (wO) mO = eO;
    @(posedge clk); #2;
    check($sformatf("%s R2 R12 flags{Z,N,C,O}", tag),
          {12'h0, flagZ, flagN, flagC, flagO}, {12'h0, mZ, mN, mC, mO});
  endtask

  initial begin
    #(20 * 200000);
    nBad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // R11: flags clear in reset
    #25;
    check("R11 reset flags", {12'h0, flagZ, flagN, flagC, flagO}, 16'h0);
    check("R9 idle result in reset", result, 16'h0);
    @(negedge clk); rstN = 1'b1;

    // arithmetic sweep with the carry forced both ways first
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          for (int cs = 0; cs < 2; cs++) begin
            runOp(2'd0, cs ? 4'd5 : 4'd4, 16'h0, 16'h0, 10'h0, 1'b1);
            runOp(2'd0, 4'(op), patVal(i), patVal(j), 10'h0, 1'b1);
          end

    // R10: disabled updates, with O set first so all four flags are exercised
    runOp(2'd1, 4'd0, 16'h7FFF, 16'h0, 10'h001, 1'b1);
    for (int op = 0; op < 12; op++)
      for (int i = 0; i < 12; i++)
        runOp(2'd0, 4'(op), patVal(i), patVal(11 - i), 10'h0, 1'b0);
    runOp(2'd1, 4'd0, 16'h7FFF, 16'h0, 10'h001, 1'b0);

    // R7: every 6-bit immediate, junk above bit 5
    for (int k = 0; k < 64; k++)
      for (int i = 0; i < 12; i++)
        runOp(2'd1, 4'd7, patVal(i), 16'hFFFF, {4'hA, 6'(k)}, 1'b1);

    // R8: every load-upper immediate, operands irrelevant
    for (int k = 0; k < 1024; k++)
      runOp(2'd2, 4'd4, patVal(k % 12), 16'hFFFF, 10'(k), 1'b1);

    // R9: idle path
    for (int i = 0; i < 12; i++)
      runOp(2'd3, 4'(i), patVal(i), patVal(i), 10'h3FF, 1'b1);

    finishRun();
  end

endmodule